// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is the per-core countdown timer of a local interrupt controller. Software loads an initial count, picks a power-of-two prescaler through a four-bit divide setting, and programs a timer entry. The entry holds an interrupt vector, a mask bit, a delivery-status bit and a mode bit that selects one-shot or periodic operation. The counter steps down once per prescaler tick and can be read at any time. Each time it runs out, an expiry is recorded.

Expiries are not delivered one for one. They are added to a saturating pending counter. While the timer entry is unmasked and the counter is nonzero, the block raises an interrupt request that carries the entry's vector. Each accepted request takes one expiry off the counter.

A software-enable input works as a global off switch. While it is low, the entry is held masked and all queued expiries are discarded. Bus decoding and the interrupt controller core that receives the request are outside this block.

Top module: `core_tick_timer`

## Requirements
- R1: After reset the current count reads 0, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), no request is raised, and the divide setting is 0, which gives divide-by-2.
- R2: The prescaler divisor comes from divide-setting bits 3, 1 and 0. With n = {bit3, bit1, bit0} + 1, the divisor is 2^(n mod 8). Bit 2 has no effect. So 0b0000 gives 2, 0b0011 gives 16, 0b1010 gives 128 and 0b1011 gives 1.
- R3: A write with select 0 (initial count) loads the counter, clears queued expiries and restarts the prescaler phase. The first decrement lands exactly one divisor of clocks after the write, and each later decrement follows one divisor of clocks after the one before.
- R4: An initial count of 0 holds the current count at 0 and produces no expiry.
- R5: In one-shot mode (entry bit 17 clear), the tick that takes the count from 1 records an expiry. The count then stays at 0 until the next initial-count write.
- R6: In periodic mode (entry bit 17 set), the tick that takes the count from 1 records an expiry and reloads the initial count. Expiries therefore recur every count × divisor clocks.
- R7: Each expiry adds one to a pending counter of PEND_W bits. The counter saturates at 2^PEND_W − 1 and never wraps.
- R8: The request output is high exactly while entry bit 16 (mask) is clear and pending is nonzero. The vector output carries entry bits 7:0. An accept that arrives while the request is high removes one pending expiry.
- R9: While the entry is masked, expiries still accumulate and no request is raised. Unmasking later raises the request for everything that has queued.
- R10: A timer-entry write (select 2) keeps only bits 7:0, 12, 16 and 17, and all other bits read back as 0. While software enable is low, the stored mask bit is forced to 1.
- R11: While software enable is low, the entry mask is set and the pending counter is held at 0. Expiries from that period are not delivered after enable returns.
- R12: A change of the divide setting takes effect at the next prescaler tick. The interval already in progress completes with the old divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en | input | 1 | Software enable; low masks the entry and drops pending expiries |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 initial count, 1 divide setting, 2 timer entry, 3 none |
| wr_data | input | 32 | Write data |
| cur_count | output | 32 | Current count |
| entry_rd | output | 32 | Timer entry read-back (bits 7:0, 12, 16, 17) |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector of the request |
| irq_ack | input | 1 | Request accepted this cycle |

## Verification
The assertions take for granted that an accept arrives only as a response to a raised request. They also assume that write strobes and the enable input change only between clock edges. The bench keeps within both assumptions: it drives every input on the falling edge, and it pulses the accept only after it has seen the request high. Initial counts and divide settings are chosen so that each expected count change falls on a known cycle offset from the initial-count write.

// File: rtl/lit_pkg.sv
package lit_pkg;

    localparam int CNT_W  = 32;
    localparam int VEC_W  = 8;
    localparam int SH_W   = 3;
    localparam int CFG_W  = 4;

    typedef enum logic [1:0] {
        SEL_INIT  = 2'd0,
        SEL_DIV   = 2'd1,
        SEL_ENTRY = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;

    typedef struct packed {
        logic             periodic;
        logic             mask;
        logic             dstat;
        logic [VEC_W-1:0] vec;
    } tmr_entry_t;

    localparam tmr_entry_t ENTRY_RESET = '{periodic: 1'b0, mask: 1'b1,
                                           dstat: 1'b0, vec: '0};

    // Odd encoding: bit 2 of the setting is skipped, and n = 8 wraps to 0.
    function automatic logic [SH_W-1:0] div_shift(input logic [CFG_W-1:0] cfg);
        logic [CFG_W-1:0] n;
        n = {1'b0, cfg[3], cfg[1:0]} + 4'd1;
        return n[SH_W-1:0];
    endfunction

    function automatic tmr_entry_t entry_from_word(input logic [31:0] w);
        tmr_entry_t e;
        e.periodic = w[17];
        e.mask     = w[16];
        e.dstat    = w[12];
        e.vec      = w[VEC_W-1:0];
        return e;
    endfunction

    function automatic logic [31:0] entry_to_word(input tmr_entry_t e);
        logic [31:0] w;
        w = '0;
        w[17] = e.periodic;
        w[16] = e.mask;
        w[12] = e.dstat;
        w[VEC_W-1:0] = e.vec;
        return w;
    endfunction

endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler
    import lit_pkg::*;
#(
    parameter int SHW = SH_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic [SHW-1:0]  sh_next,
    output logic            tick
);
    localparam int PC_W = (1 << SHW) - 1;

    logic [PC_W-1:0] pcnt;
    logic [SHW-1:0]  sh_q;
    logic [PC_W:0]   full;
    logic [PC_W-1:0] limit;

    always_comb begin
        full  = (PC_W+1)'(1) << sh_q;
        limit = PC_W'(full - 1'b1);
        tick  = !restart && (pcnt == limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
            sh_q <= div_shift('0);
        end else if (restart || tick) begin
            pcnt <= '0;
            sh_q <= sh_next;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    a_r12_tick_restarts: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pcnt == '0));

    a_r2_phase_in_range: assert property (@(posedge clk) disable iff (rst)
        pcnt <= limit);

endmodule

// File: rtl/lit_countdown.sv
module lit_countdown
    import lit_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    input  logic          periodic,
    output logic [CW-1:0] count,
    output logic          expire
);
    logic [CW-1:0] init_q;

    assign expire = tick && !load && (count == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= '0;
            init_q <= '0;
        end else if (load) begin
            count  <= load_val;
            init_q <= load_val;
        end else if (tick && count != '0) begin
            if (count == CW'(1))
                count <= periodic ? init_q : '0;
            else
                count <= count - 1'b1;
        end
    end

    a_r3_load_value: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_val)));

    a_r5_oneshot_sticks: assert property (@(posedge clk) disable iff (rst)
        (!load && !periodic && count == '0) |=> (count == '0));

    a_r6_periodic_reload: assert property (@(posedge clk) disable iff (rst)
        (expire && periodic) |=> (count == init_q));

    a_r4_zero_no_expiry: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |-> !expire);

endmodule

// File: rtl/lit_pending.sv
module lit_pending #(
    parameter int PW = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    input  logic allow,
    input  logic ack,
    output logic req
);
    localparam logic [PW-1:0] PMAX = '1;

    logic [PW-1:0] pend;
    logic          inc_eff;
    logic          dec;

    assign req     = allow && (pend != '0);
    assign dec     = ack && req;
    assign inc_eff = inc && (pend != PMAX);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= '0;
        end else begin
            case ({inc_eff, dec})
                2'b10:   pend <= pend + 1'b1;
                2'b01:   pend <= pend - 1'b1;
                default: pend <= pend;
            endcase
        end
    end

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (pend == PMAX && !clr && !dec) |=> (pend == PMAX));

    a_r8_accept_drains_one: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc && !clr) |=> (pend == $past(pend) - 1'b1));

    a_r8_ack_only_on_req: assert property (@(posedge clk) disable iff (rst)
        ack |-> req);

endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
    import lit_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_en,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic [31:0] cur_count,
    output logic [31:0] entry_rd,
    output logic        irq_req,
    output logic [7:0]  irq_vec,
    input  logic        irq_ack
);
    tmr_entry_t       entry_q;
    logic [CFG_W-1:0] cfg_q;
    logic             wr_init, wr_div, wr_entry;
    logic             tick, expire;

    assign wr_init  = wr_en && (wr_sel_e'(wr_sel) == SEL_INIT);
    assign wr_div   = wr_en && (wr_sel_e'(wr_sel) == SEL_DIV);
    assign wr_entry = wr_en && (wr_sel_e'(wr_sel) == SEL_ENTRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (wr_div) begin
            cfg_q <= wr_data[CFG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_q <= ENTRY_RESET;
        end else if (wr_entry) begin
            entry_q      <= entry_from_word(wr_data);
            entry_q.mask <= wr_data[16] || !sw_en;
        end else if (!sw_en) begin
            entry_q.mask <= 1'b1;
        end
    end

    lit_prescaler #(.SHW(SH_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (wr_init),
        .sh_next (div_shift(cfg_q)),
        .tick    (tick)
    );

    lit_countdown #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_init),
        .load_val (wr_data),
        .tick     (tick),
        .periodic (entry_q.periodic),
        .count    (cur_count),
        .expire   (expire)
    );

    lit_pending #(.PW(PEND_W)) u_pend (
        .clk   (clk),
        .rst   (rst),
        .clr   (wr_init || !sw_en),
        .inc   (expire),
        .allow (!entry_q.mask),
        .ack   (irq_ack),
        .req   (irq_req)
    );

    assign entry_rd = entry_to_word(entry_q);
    assign irq_vec  = entry_q.vec;

    a_r8_req_only_unmasked: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> !entry_rd[16]);

    a_r11_swoff_masks: assert property (@(posedge clk) disable iff (rst)
        !sw_en |=> (entry_rd[16] && !irq_req));

    a_r10_entry_clean: assert property (@(posedge clk) disable iff (rst)
        (entry_rd[31:18] == '0) && (entry_rd[15:13] == '0) && (entry_rd[11:8] == '0));

endmodule

// File: tb/sim_core_tick_timer.sv
module sim_core_tick_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic        sw_en;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] cur_count;
    logic [31:0] entry_rd;
    logic        irq_req;
    logic [7:0]  irq_vec;
    logic        irq_ack;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    core_tick_timer u0 (
        .clk(clk), .rst(rst), .sw_en(sw_en), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cur_count(cur_count), .entry_rd(entry_rd),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; sw_en = 1'b1; wr_en = 1'b0; wr_sel = 2'd3; wr_data = '0; irq_ack = 1'b0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 count", cur_count, 32'd0);
        check("R1 entry", entry_rd, 32'h0001_0000);
        check("R1 req", {31'd0, irq_req}, 32'd0);
        // reset divide setting 0 -> divide by 2
        wr(2'd0, 32'd5);
        wait_cyc(1);
        check("R1 div2 hold", cur_count, 32'd5);
        wait_cyc(1);
        check("R1 div2 step", cur_count, 32'd4);
    endtask

    task automatic t_divide(input logic [3:0] cfg, input int div);
        wr(2'd1, {28'd0, cfg});
        wr(2'd0, 32'd3);
        if (div > 1) begin
            wait_cyc(div - 1);
            check($sformatf("R2 cfg%0h before", cfg), cur_count, 32'd3);
            wait_cyc(1);
        end else begin
            wait_cyc(1);
        end
        check($sformatf("R2 cfg%0h first step", cfg), cur_count, 32'd2);
        wait_cyc(div);
        check($sformatf("R3 cfg%0h second step", cfg), cur_count, 32'd1);
    endtask

    task automatic t_oneshot();
        wr(2'd1, 32'hB);                   // divide by 1
        wr(2'd2, 32'h0000_0041);           // unmasked, one-shot, vector 0x41
        check("R10 entry write", entry_rd, 32'h0000_0041);
        wr(2'd0, 32'd4);
        wait_cyc(3);
        check("R5 count before expiry", cur_count, 32'd1);
        check("R5 no req yet", {31'd0, irq_req}, 32'd0);
        wait_cyc(1);
        check("R5 count zero", cur_count, 32'd0);
        check("R8 req raised", {31'd0, irq_req}, 32'd1);
        check("R8 vector", {24'd0, irq_vec}, 32'h41);
        wait_cyc(5);
        check("R5 sticks at zero", cur_count, 32'd0);
        ack_once();
        check("R8 req dropped after accept", {31'd0, irq_req}, 32'd0);
    endtask

    task automatic t_zero_init();
        wr(2'd0, 32'd0);
        wait_cyc(20);
        check("R4 count zero", cur_count, 32'd0);
        check("R4 no expiry", {31'd0, irq_req}, 32'd0);
    endtask

    task automatic t_periodic();
        int reqs;
        wr(2'd2, 32'h0002_0022);           // periodic, unmasked
        wr(2'd0, 32'd3);
        wait_cyc(3);
        check("R6 reload", cur_count, 32'd3);
        check("R6 first expiry", {31'd0, irq_req}, 32'd1);
        ack_once();                        // m=4
        wait_cyc(1);
        check("R6 counting again", cur_count, 32'd1);
        wait_cyc(1);                       // m=6 second expiry
        check("R6 second reload", cur_count, 32'd3);
        check("R6 second expiry", {31'd0, irq_req}, 32'd1);
        reqs = 0;
        wr(2'd0, 32'd0);                   // stop and clear
        check("R3 load clears pending", {31'd0, irq_req}, 32'd0);
        reqs = reqs + 0;
    endtask

    task automatic t_saturate();
        int acks;
        wr(2'd2, 32'h0003_0007);           // periodic, masked
        wr(2'd0, 32'd1);                   // expiry every clock
        wait_cyc(30);
        check("R9 masked no req", {31'd0, irq_req}, 32'd0);
        wr(2'd2, 32'h0001_0007);           // one-shot, still masked
        wait_cyc(3);
        wr(2'd2, 32'h0000_0007);           // unmask
        check("R9 unmask raises req", {31'd0, irq_req}, 32'd1);
        acks = 0;
        for (int i = 0; i < 40 && irq_req; i++) begin
            ack_once();
            acks++;
        end
        check("R7 saturated at 15", acks, 32'd15);
    endtask

    task automatic t_div_change();
        wr(2'd2, 32'h0001_0000);
        wr(2'd1, 32'h0);                   // divide by 2
        wr(2'd0, 32'd10);                  // m=0
        wr(2'd1, 32'h2);                   // divide by 8, lands at m=1
        wait_cyc(1);
        check("R12 old divisor completes", cur_count, 32'd9);
        wait_cyc(7);
        check("R12 new divisor pending", cur_count, 32'd9);
        wait_cyc(1);
        check("R12 new divisor applied", cur_count, 32'd8);
    endtask

    task automatic t_swen();
        wr(2'd1, 32'hB);
        wr(2'd2, 32'h0000_1000 | 32'hFFFC_E000 | 32'h0000_0033);
        check("R10 unkept bits dropped", entry_rd, 32'h0000_1033);
        sw_en = 1'b0;
        wait_cyc(1);
        check("R11 mask forced", entry_rd, 32'h0001_1033);
        wr(2'd2, 32'h0000_0055);
        check("R10 forced masked while off", entry_rd, 32'h0001_0055);
        sw_en = 1'b1;
        wr(2'd2, 32'h0001_0055);           // masked, one-shot
        wr(2'd0, 32'd2);
        wait_cyc(3);                       // expiry queued while masked
        sw_en = 1'b0;
        wait_cyc(1);
        sw_en = 1'b1;
        wr(2'd2, 32'h0000_0055);
        check("R11 pending dropped", {31'd0, irq_req}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_divide(4'b0000, 2);
        t_divide(4'b0100, 2);
        t_divide(4'b1011, 1);
        t_divide(4'b0011, 16);
        t_divide(4'b1010, 128);
        t_oneshot();
        t_zero_init();
        t_periodic();
        t_saturate();
        t_div_change();
        t_swen();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule